// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the address-latch strobe (ALE, active high) and the program-store strobe (PSEN, active low) of an 8051-style external memory bus. It runs on the oscillator clock and divides it into machine cycles of twelve clocks. Each machine cycle has two halves of six clocks. Each half opens with an ALE window and ends with a PSEN window. Besides the strobes, the block drives the low address byte and the high port. The low byte is latched at the start of every ALE window, so it is steady when ALE falls. The high port carries either the upper address byte, with strong drive, or the value of the high-port register.

The CPU presents its bus mode for the next machine cycle on the control inputs. These are: code fetched from external memory, a data access request with its addressing width, a code-table read in progress, and the ALE-suppress bit. The block samples all of them on the last clock of a machine cycle and applies them to the whole of the following cycle. In a data access cycle the first ALE pulse and both PSEN pulses are left out. When the ALE-suppress bit is set, ALE stays low except in data access or code-table read cycles. The suppress bit has no effect while code comes from external memory.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: While `rst` is high, `ale_o` is 0 and `psen_n_o` is 1. The first machine cycle after reset runs as an internal-execution cycle with ALE enabled.
- R2: When ALE is enabled, `ale_o` is 1 on machine-cycle clocks 0, 1, 6 and 7 (clock 0 being the first output clock of the cycle) and 0 on all other clocks. This gives two pulses per cycle, at one sixth of the clock rate.
- R3: In a cycle with `code_ext_i` sampled as 1 and no data access, `psen_n_o` is 0 on clocks 3, 4, 5, 9, 10 and 11 and 1 otherwise. In a cycle with `code_ext_i` sampled as 0, `psen_n_o` stays 1. `ale_o` and `psen_n_o` are never active together.
- R4: In a data access cycle (`data_req_i` sampled as 1), the ALE pulse on clocks 0 and 1 is left out and the pulse on clocks 6 and 7 is kept. The following non-data cycle has both pulses again.
- R5: In a data access cycle, `psen_n_o` stays 1 for the whole cycle, even when `code_ext_i` is 1.
- R6: With `ale_off_i` = 1, `code_ext_i` = 0, `movc_i` = 0 and no data access, `ale_o` stays 0 for the whole cycle.
- R7: With `ale_off_i` = 1 and `code_ext_i` = 0, a cycle with `movc_i` = 1 has both ALE pulses, and a data access cycle has its second ALE pulse.
- R8: With `code_ext_i` = 1, `ale_off_i` = 1 has no effect: both ALE pulses appear as in R2.
- R9: `hi_o` carries `addr_i[15:8]` and `hi_strong_o` is 1 in a data cycle with `data_wide_i` = 1, and in a non-data cycle with `code_ext_i` = 1. Otherwise `hi_o` carries `hi_reg_i` as sampled at the previous clock, and `hi_strong_o` is 0.
- R10: `lo_o` shows `addr_i[7:0]` as sampled at the edge that starts each ALE window (clocks 0 and 6). It holds that value through the window and until the next window starts, even if `addr_i` changes in between.
- R11: The control inputs are sampled only at the last clock of a machine cycle. A data request raised and withdrawn within a cycle changes neither that cycle nor the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_ext_i | input | 1 | Code is fetched from external program memory |
| data_req_i | input | 1 | Next machine cycle is an external data access |
| data_wide_i | input | 1 | Data access uses 16-bit addressing (0: 8-bit) |
| movc_i | input | 1 | Code-table read in progress |
| ale_off_i | input | 1 | ALE-suppress control bit |
| addr_i | input | 16 | Bus address |
| hi_reg_i | input | 8 | High-port register value |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program store strobe, active low |
| hi_o | output | 8 | High-port byte |
| hi_strong_o | output | 1 | High port drives address bits with strong pull-up |
| lo_o | output | 8 | Latched low address byte |

## Verification
The bound checker watches, on every clock, a set of rules that hold in any cycle whatever the mode: the reset levels of the strobes, that ALE and PSEN never overlap, the minimum ALE pulse width, that the low byte holds while ALE is high, and that the high port falls back to the register value whenever strong drive is off. Which pulses appear in which cycle can only be shown by the directed scenarios. These cover the slot pattern of each mode, the pulse left out in data cycles, ALE suppression and its override, the choice of high-byte source, and the boundary-only sampling. Each scenario compares every output clock of the cycle against a slot table computed independently of the design.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   // bus mode of one machine cycle, sampled at the cycle boundary
   typedef struct packed {
      logic code_ext;
      logic data_req;
      logic data_wide;
      logic movc;
      logic ale_off;
   } cyc_mode_t;

   typedef enum logic {
      HI_FROM_REG  = 1'b0,
      HI_FROM_ADDR = 1'b1
   } hi_src_e;

endpackage

// File: rtl/ebs_phase_ctr.sv
module ebs_phase_ctr #(
   parameter int CYCLE_CLKS = 12,
   localparam int PW = $clog2(CYCLE_CLKS),
   localparam int HALF = CYCLE_CLKS / 2
) (
   input  logic          clk,
   input  logic          rst,
   output logic          cyc_last_o,
   output logic          win_start_o,
   output logic          second_half_o,
   output logic [PW-1:0] win_pos_o
);

   localparam logic [PW-1:0] LAST_C = PW'(CYCLE_CLKS - 1);
   localparam logic [PW-1:0] HALF_C = PW'(HALF);

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
      end else if (phase_q == LAST_C) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   always_comb begin
      cyc_last_o    = (phase_q == LAST_C);
      second_half_o = (phase_q >= HALF_C);
      win_pos_o     = second_half_o ? (phase_q - HALF_C) : phase_q;
      win_start_o   = (win_pos_o == '0);
   end

endmodule

// File: rtl/ebs_mode_latch.sv
module ebs_mode_latch
   import ebs_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      cyc_last_i,
   input  cyc_mode_t mode_i,
   output cyc_mode_t mode_o
);

   // the mode only moves on the last clock of a machine cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         mode_o <= '0;
      end else if (cyc_last_i) begin
         mode_o <= mode_i;
      end
   end

endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
   import ebs_pkg::*;
#(
   parameter int CYCLE_CLKS    = 12,
   parameter int ALE_WIDTH     = 2,
   parameter int PSEN_START    = 3,
   parameter bit SKIP_LATE_ALE = 1'b0,
   localparam int PW = $clog2(CYCLE_CLKS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          second_half_i,
   input  logic [PW-1:0] win_pos_i,
   input  cyc_mode_t     mode_i,
   output logic          ale_o,
   output logic          psen_n_o
);

   localparam logic [PW-1:0] ALE_W_C  = PW'(ALE_WIDTH);
   localparam logic [PW-1:0] PSEN_S_C = PW'(PSEN_START);

   logic ale_win, psen_win, ale_en, ale_skip;
   logic ale_nxt, psen_nxt;

   // which of the two ALE pulses a data cycle gives up
   generate
      if (SKIP_LATE_ALE) begin : g_skip_late
         assign ale_skip = mode_i.data_req & second_half_i;
      end else begin : g_skip_early
         assign ale_skip = mode_i.data_req & ~second_half_i;
      end
   endgenerate

   always_comb begin
      ale_win  = (win_pos_i < ALE_W_C);
      psen_win = (win_pos_i >= PSEN_S_C);
      // suppression is overridden by external code and by bus-using cycles
      ale_en   = ~mode_i.ale_off | mode_i.code_ext | mode_i.data_req | mode_i.movc;
      ale_nxt  = ale_win & ale_en & ~ale_skip;
      psen_nxt = psen_win & mode_i.code_ext & ~mode_i.data_req;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ale_o    <= 1'b0;
         psen_n_o <= 1'b1;
      end else begin
         ale_o    <= ale_nxt;
         psen_n_o <= ~psen_nxt;
      end
   end

endmodule

// File: rtl/ebs_addr_path.sv
module ebs_addr_path
   import ebs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LO_W   = 8,
   localparam int HI_W  = ADDR_W - LO_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              win_start_i,
   input  cyc_mode_t         mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [HI_W-1:0]   hi_reg_i,
   output logic [HI_W-1:0]   hi_o,
   output logic              hi_strong_o,
   output logic [LO_W-1:0]   lo_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [HI_W-1:0]   reg_q;
   hi_src_e           src_q;
   hi_src_e           src_nxt;

   always_comb begin
      if (mode_i.data_req) begin
         src_nxt = mode_i.data_wide ? HI_FROM_ADDR : HI_FROM_REG;
      end else begin
         src_nxt = mode_i.code_ext ? HI_FROM_ADDR : HI_FROM_REG;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         reg_q  <= '0;
         src_q  <= HI_FROM_REG;
      end else begin
         if (win_start_i) begin
            addr_q <= addr_i;
         end
         reg_q <= hi_reg_i;
         src_q <= src_nxt;
      end
   end

   assign lo_o        = addr_q[LO_W-1:0];
   assign hi_strong_o = (src_q == HI_FROM_ADDR);
   assign hi_o        = hi_strong_o ? addr_q[ADDR_W-1:LO_W] : reg_q;

endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
   import ebs_pkg::*;
#(
   parameter int CYCLE_CLKS    = 12,
   parameter int ALE_WIDTH     = 2,
   parameter int PSEN_START    = 3,
   parameter bit SKIP_LATE_ALE = 1'b0,
   parameter int ADDR_W        = 16,
   parameter int LO_W          = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   code_ext_i,
   input  logic                   data_req_i,
   input  logic                   data_wide_i,
   input  logic                   movc_i,
   input  logic                   ale_off_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [ADDR_W-LO_W-1:0] hi_reg_i,
   output logic                   ale_o,
   output logic                   psen_n_o,
   output logic [ADDR_W-LO_W-1:0] hi_o,
   output logic                   hi_strong_o,
   output logic [LO_W-1:0]        lo_o
);

   localparam int PW   = $clog2(CYCLE_CLKS);
   localparam int HALF = CYCLE_CLKS / 2;

   generate
      if ((CYCLE_CLKS % 2) != 0 || CYCLE_CLKS < 4) begin : g_bad_cycle
         $error("CYCLE_CLKS must be even and at least 4");
      end
      if (ALE_WIDTH < 1 || ALE_WIDTH >= PSEN_START) begin : g_bad_ale
         $error("ALE_WIDTH must be at least 1 and end before PSEN_START");
      end
      if (PSEN_START >= HALF) begin : g_bad_psen
         $error("PSEN_START must fall inside a half cycle");
      end
      if (LO_W < 1 || ADDR_W <= LO_W) begin : g_bad_addr
         $error("ADDR_W must exceed LO_W");
      end
   endgenerate

   cyc_mode_t     mode_in, mode_q;
   logic          cyc_last, win_start, second_half;
   logic [PW-1:0] win_pos;

   always_comb begin
      mode_in.code_ext  = code_ext_i;
      mode_in.data_req  = data_req_i;
      mode_in.data_wide = data_wide_i;
      mode_in.movc      = movc_i;
      mode_in.ale_off   = ale_off_i;
   end

   ebs_phase_ctr #(
      .CYCLE_CLKS(CYCLE_CLKS)
   ) u_phase (
      .clk          (clk),
      .rst          (rst),
      .cyc_last_o   (cyc_last),
      .win_start_o  (win_start),
      .second_half_o(second_half),
      .win_pos_o    (win_pos)
   );

   ebs_mode_latch u_mode (
      .clk       (clk),
      .rst       (rst),
      .cyc_last_i(cyc_last),
      .mode_i    (mode_in),
      .mode_o    (mode_q)
   );

   ebs_strobe_gen #(
      .CYCLE_CLKS   (CYCLE_CLKS),
      .ALE_WIDTH    (ALE_WIDTH),
      .PSEN_START   (PSEN_START),
      .SKIP_LATE_ALE(SKIP_LATE_ALE)
   ) u_strobe (
      .clk          (clk),
      .rst          (rst),
      .second_half_i(second_half),
      .win_pos_i    (win_pos),
      .mode_i       (mode_q),
      .ale_o        (ale_o),
      .psen_n_o     (psen_n_o)
   );

   ebs_addr_path #(
      .ADDR_W(ADDR_W),
      .LO_W  (LO_W)
   ) u_addr (
      .clk        (clk),
      .rst        (rst),
      .win_start_i(win_start),
      .mode_i     (mode_q),
      .addr_i     (addr_i),
      .hi_reg_i   (hi_reg_i),
      .hi_o       (hi_o),
      .hi_strong_o(hi_strong_o),
      .lo_o       (lo_o)
   );

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
   parameter int ADDR_W    = 16,
   parameter int LO_W      = 8,
   parameter int ALE_WIDTH = 2
) (
   input logic                   clk,
   input logic                   rst,
   input logic [ADDR_W-LO_W-1:0] hi_reg_i,
   input logic                   ale_o,
   input logic                   psen_n_o,
   input logic [ADDR_W-LO_W-1:0] hi_o,
   input logic                   hi_strong_o,
   input logic [LO_W-1:0]        lo_o
);

   // R1: reset holds both strobes inactive
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!ale_o && psen_n_o));

   // R3: the two strobes never overlap
   a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(ale_o && !psen_n_o));

   // R10: low byte steady while ALE is high
   a_r10_lo_hold: assert property (@(posedge clk) disable iff (rst)
      (ale_o && $past(ale_o)) |-> $stable(lo_o));

   // R9: without strong drive the port shows the register value
   a_r9_reg_source: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !hi_strong_o) |-> (hi_o == $past(hi_reg_i)));

   generate
      if (ALE_WIDTH >= 2) begin : g_width
         // R2: an ALE pulse lasts at least two clocks
         a_r2_ale_width: assert property (@(posedge clk) disable iff (rst)
            $rose(ale_o) |=> ale_o);
      end
   endgenerate

endmodule

bind ext_bus_strobe_seq ebs_checker #(
   .ADDR_W   (ADDR_W),
   .LO_W     (LO_W),
   .ALE_WIDTH(ALE_WIDTH)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .hi_reg_i   (hi_reg_i),
   .ale_o      (ale_o),
   .psen_n_o   (psen_n_o),
   .hi_o       (hi_o),
   .hi_strong_o(hi_strong_o),
   .lo_o       (lo_o)
);

// File: tb/ext_bus_strobe_seq_test.sv
module ext_bus_strobe_seq_test;

   localparam int CLK_P    = 10;
   localparam int WATCHDOG = 200000;

   logic clk = 1'b0;
   always #(CLK_P / 2) clk = ~clk;

   logic        rst, code_ext_i, data_req_i, data_wide_i, movc_i, ale_off_i;
   logic [15:0] addr_i;
   logic [7:0]  hi_reg_i;
   logic        ale_o, psen_n_o, hi_strong_o;
   logic [7:0]  hi_o, lo_o;

   ext_bus_strobe_seq uut (
      .clk        (clk),
      .rst        (rst),
      .code_ext_i (code_ext_i),
      .data_req_i (data_req_i),
      .data_wide_i(data_wide_i),
      .movc_i     (movc_i),
      .ale_off_i  (ale_off_i),
      .addr_i     (addr_i),
      .hi_reg_i   (hi_reg_i),
      .ale_o      (ale_o),
      .psen_n_o   (psen_n_o),
      .hi_o       (hi_o),
      .hi_strong_o(hi_strong_o),
      .lo_o       (lo_o)
   );

   typedef struct packed {
      logic        fetch;
      logic        off;
      logic        req;
      logic        wide;
      logic        movc;
      logic [15:0] addr;
      logic [7:0]  p2;
   } cfg_t;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   cfg_t  prv;
   string prv_tag;

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic ale_exp(cfg_t c, int k);
      logic en;
      en = !c.off || c.fetch || c.req || c.movc;
      return ((k % 6) < 2) && en && !(c.req && k < 6);
   endfunction

   function automatic logic psen_n_exp(cfg_t c, int k);
      return !(((k % 6) >= 3) && c.fetch && !c.req);
   endfunction

   task automatic apply(cfg_t c);
      code_ext_i  = c.fetch;
      ale_off_i   = c.off;
      data_req_i  = c.req;
      data_wide_i = c.wide;
      movc_i      = c.movc;
      addr_i      = c.addr;
      hi_reg_i    = c.p2;
   endtask

   task automatic check_slot(cfg_t c, int k, string tag, bit full, logic [15:0] a);
      logic drive;
      chk(tag, $sformatf("ale slot %0d", k), 16'(ale_o), 16'(ale_exp(c, k)));
      chk(tag, $sformatf("psen_n slot %0d", k), 16'(psen_n_o), 16'(psen_n_exp(c, k)));
      if (full) begin
         drive = c.req ? c.wide : c.fetch;
         chk(tag, $sformatf("strong slot %0d", k), 16'(hi_strong_o), 16'(drive));
         chk(tag, $sformatf("hi slot %0d", k), 16'(hi_o), 16'(drive ? a[15:8] : c.p2));
         chk(tag, $sformatf("lo slot %0d", k), 16'(lo_o), 16'(a[7:0]));
      end
   endtask

   // drive the mode for the next cycle, then check that cycle slot by slot
   task automatic play(cfg_t c, string tag, bit glitch, bit mid, logic [15:0] a2);
      apply(c);
      @(posedge clk); @(negedge clk);
      check_slot(prv, 11, prv_tag, 1'b0, prv.addr);
      for (int k = 0; k < 11; k++) begin
         @(posedge clk); @(negedge clk);
         check_slot(c, k, tag, 1'b1, (mid && k >= 6) ? a2 : c.addr);
         if (mid && k == 2) addr_i = a2;
         if (glitch && k == 3) data_req_i = 1'b1;
         if (glitch && k == 7) data_req_i = 1'b0;
      end
      prv     = c;
      prv_tag = tag;
   endtask

   function automatic cfg_t mk(logic f, logic o, logic r, logic w, logic m,
                               logic [15:0] a, logic [7:0] p);
      cfg_t c;
      c.fetch = f; c.off = o; c.req = r; c.wide = w; c.movc = m;
      c.addr = a; c.p2 = p;
      return c;
   endfunction

   task automatic t_reset();
      rst = 1'b1;
      apply(mk(1, 0, 1, 1, 1, 16'hFFFF, 8'hFF));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "ale in reset", 16'(ale_o), 16'h0);
      chk("R1", "psen_n in reset", 16'(psen_n_o), 16'h1);
      @(posedge clk); @(negedge clk);
      chk("R1", "ale in reset (held)", 16'(ale_o), 16'h0);
      chk("R1", "psen_n in reset (held)", 16'(psen_n_o), 16'h1);
   endtask

   task automatic t_first_cycle();
      cfg_t z;
      z = mk(0, 0, 0, 0, 0, 16'h0000, 8'h00);
      apply(z);
      rst = 1'b0;
      for (int k = 0; k < 11; k++) begin
         @(posedge clk); @(negedge clk);
         check_slot(z, k, "R1 R2 R3", 1'b1, z.addr);
      end
      prv     = z;
      prv_tag = "R1 R2 R3";
   endtask

   task automatic t_fetch();
      play(mk(1, 0, 0, 0, 0, 16'h1234, 8'hA5), "R2 R3 R9", 0, 0, 16'h0);
      play(mk(1, 0, 0, 1, 0, 16'h5678, 8'h0F), "R3 R9", 0, 0, 16'h0);
   endtask

   task automatic t_data16();
      play(mk(1, 0, 1, 1, 0, 16'hBEEF, 8'h11), "R4 R5 R9", 0, 0, 16'h0);
      play(mk(1, 0, 0, 0, 0, 16'h2468, 8'h22), "R4", 0, 0, 16'h0);
   endtask

   task automatic t_data8();
      play(mk(1, 0, 1, 0, 0, 16'hCAFE, 8'h3C), "R5 R9", 0, 0, 16'h0);
      play(mk(0, 0, 0, 1, 0, 16'h9ABC, 8'h77), "R3 R9", 0, 0, 16'h0);
   endtask

   task automatic t_ale_off();
      play(mk(0, 1, 0, 0, 0, 16'h4321, 8'h44), "R6", 0, 0, 16'h0);
      play(mk(0, 1, 0, 0, 1, 16'h8765, 8'h55), "R7", 0, 0, 16'h0);
      play(mk(0, 1, 1, 1, 0, 16'hF00D, 8'h66), "R7 R4", 0, 0, 16'h0);
      play(mk(0, 1, 0, 0, 0, 16'h0BAD, 8'h88), "R6", 0, 0, 16'h0);
   endtask

   task automatic t_override();
      play(mk(1, 1, 0, 0, 0, 16'h1357, 8'h99), "R8", 0, 0, 16'h0);
   endtask

   task automatic t_lo_byte();
      play(mk(1, 0, 0, 0, 0, 16'h1122, 8'hAA), "R10", 0, 1, 16'h3344);
      play(mk(0, 0, 1, 1, 0, 16'h5566, 8'hBB), "R10", 0, 1, 16'h7788);
   endtask

   task automatic t_glitch();
      play(mk(1, 0, 0, 1, 0, 16'hD00D, 8'hCC), "R11", 1, 0, 16'h0);
      play(mk(1, 0, 0, 1, 0, 16'hE00E, 8'hDD), "R11", 0, 0, 16'h0);
   endtask

   initial begin
      t_reset();
      t_first_cycle();
      t_fetch();
      t_data16();
      t_data8();
      t_ale_off();
      t_override();
      t_lo_byte();
      t_glitch();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * WATCHDOG);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule